// File: doc/BRIEF.md
# Windowed Watchdog Timer with Low-Power Freeze

This block watches over software by counting ticks of a slow oscillator, which is modelled as a clock-enable input inside one synchronous clock domain. If software does not restart the count in time, the counter reaches the selected overflow length and the block issues a single-cycle reset request. A restart is made by writing one specific key byte. The write is honoured only while the restart window is open, which is the closing part of each period. A write with the wrong byte, or a write made too early, is treated as a fault and causes an immediate reset request.

The configuration comes from static option pins. A 3-bit length code selects a period of 2^(10+n) ticks. A 2-bit window code selects the open share of the period. A lock flag decides whether the slow oscillator may be stopped. When the oscillator is stoppable, the halt, stop and oscillator-stop requests freeze the count. The count keeps its value and resumes from that value afterwards. When the lock flag is set, these requests have no effect. One combination of the codes is forbidden. The block flags it and runs with the window fully open.

Top module: `slow_window_watchdog`

## Requirements
- R1: The counter advances by one only on cycles where `slow_tick` is high. With restarts absent, the reset request appears exactly 2^(10+`opt_ovf_sel`) ticks after the counter was last zero.
- R2: The overflow reset request `wdt_reset` is high for exactly one cycle. The counter is zero afterwards, so the next overflow comes one full period later.
- R3: A write of 0xAC while the window is open clears the counter to zero and raises no reset request. The next overflow then comes one full period after the write.
- R4: The window opens when the count reaches half the period for window code 00, and a quarter of the period for code 01. For codes 10 and 11 it is open from count zero. It stays open until overflow.
- R5: A write with any byte other than 0xAC, or a write while the window is closed, gives a one-cycle `wdt_reset` in the cycle after the write. The counter is cleared at the same time.
- R6: With `opt_osc_locked` = 0, each cycle in which `halt_req` or `stop_req` is high leaves the counter unchanged. Counting resumes from the held value, so the overflow is delayed by the number of frozen cycles.
- R7: With `opt_osc_locked` = 0, `osc_stop_req` also freezes the counter in the same way. With `opt_osc_locked` = 1, `halt_req`, `stop_req` and `osc_stop_req` have no effect on counting.
- R8: Length code 000 together with window code 00 sets `cfg_error`. That setting then runs with the window open over the whole period.
- R9: While `rst_n` is low, `wdt_reset` is low and the counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow-oscillator clock enable, one pulse per tick |
| opt_ovf_sel | input | 3 | Period code n, period = 2^(10+n) ticks |
| opt_win_sel | input | 2 | Window code: 00 half, 01 three quarters, 1x full period open |
| opt_osc_locked | input | 1 | 1 = slow oscillator cannot be stopped, counting never freezes |
| halt_req | input | 1 | Halt mode request |
| stop_req | input | 1 | Stop mode request |
| osc_stop_req | input | 1 | Software request to stop the slow oscillator |
| wr_en | input | 1 | Write strobe to the restart register |
| wr_data | input | 8 | Byte written to the restart register |
| wdt_reset | output | 1 | Reset request, one cycle per event |
| cfg_error | output | 1 | Forbidden option combination present |

## Verification
The checker verifies several rules on every cycle. A frozen counter keeps its value. A running counter steps by exactly one. An accepted key leaves the counter at zero without a reset. A rejected write or an overflow is followed by a reset request with the counter at zero. A forbidden setting always shows an open window. Only the bench scenarios can show the absolute timing: that each period really lasts 2^(10+n) ticks, that the window edges fall on the half and quarter counts, and that freezes add exactly their length to the overflow time. The bench measures these as pulse cycle numbers against values it derives from the requirements.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned WIN_W = 2;

  typedef enum logic [WIN_W-1:0] {
    WIN_HALF     = 2'd0,
    WIN_3QUARTER = 2'd1,
    WIN_FULL     = 2'd2,
    WIN_FULL_ALT = 2'd3
  } win_mode_e;

  // period length in ticks for a given length code
  function automatic logic [31:0] period_ticks(int unsigned base_exp, int unsigned code);
    return 32'd1 << (base_exp + code);
  endfunction

  // first count value at which a restart is legal
  function automatic logic [31:0] window_start(logic [31:0] period, win_mode_e mode);
    case (mode)
      WIN_HALF:     return period >> 1;
      WIN_3QUARTER: return period >> 2;
      default:      return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/wdg_cfg_decode.sv
module wdg_cfg_decode
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_EXP = 10,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned CNT_W    = BASE_EXP + (1 << SEL_W)
) (
  input  logic [SEL_W-1:0] ovf_sel,
  input  logic [WIN_W-1:0] win_sel,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] open_from,
  output logic             bad_combo
);

  win_mode_e   eff_mode;
  logic [31:0] period_w;
  logic [31:0] open_w;

  always_comb begin
    bad_combo = (ovf_sel == '0) && (win_sel == WIN_W'(WIN_HALF));
    eff_mode  = bad_combo ? WIN_FULL : win_mode_e'(win_sel);
    period_w  = period_ticks(BASE_EXP, 32'(ovf_sel));
    open_w    = window_start(period_w, eff_mode);
    period    = CNT_W'(period_w);
    open_from = CNT_W'(open_w);
  end

endmodule

// File: rtl/wdg_run_ctrl.sv
module wdg_run_ctrl (
  input  logic tick,
  input  logic osc_locked,
  input  logic halt_req,
  input  logic stop_req,
  input  logic osc_stop_req,
  output logic frozen,
  output logic run
);

  always_comb begin
    frozen = !osc_locked && (halt_req || stop_req || osc_stop_req);
    run    = tick && !frozen;
  end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] open_from,
  output logic [CNT_W-1:0] count,
  output logic             last_tick,
  output logic             win_open
);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (run)    count <= count + 1'b1;
  end

  always_comb begin
    last_tick = (count == period - 1'b1);
    win_open  = (count >= open_from);
  end

endmodule

// File: rtl/wdg_restart_gate.sv
module wdg_restart_gate #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hAC
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_open,
  output logic              key_ok,
  output logic              key_bad
);

  logic data_match;

  always_comb begin
    data_match = (wr_data == KEY);
    key_ok     = wr_en && data_match && win_open;
    key_bad    = wr_en && !key_ok;
  end

endmodule

// File: rtl/slow_window_watchdog.sv
module slow_window_watchdog #(
  parameter int unsigned BASE_EXP = 10,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [SEL_W-1:0]  opt_ovf_sel,
  input  logic [1:0]        opt_win_sel,
  input  logic              opt_osc_locked,
  input  logic              halt_req,
  input  logic              stop_req,
  input  logic              osc_stop_req,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wdt_reset,
  output logic              cfg_error
);

  localparam int unsigned CNT_W = BASE_EXP + (1 << SEL_W);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] open_from;
  logic [CNT_W-1:0] count;
  logic             bad_combo;
  logic             frozen;
  logic             cnt_run;
  logic             last_tick;
  logic             win_open;
  logic             key_ok;
  logic             key_bad;
  logic             ovf_evt;
  logic             fault_evt;
  logic             cnt_clear;

  // observation wires for the bound checker
  logic [31:0]      obs_count;
  logic [31:0]      obs_period;

  wdg_cfg_decode #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cfg (
    .ovf_sel   (opt_ovf_sel),
    .win_sel   (opt_win_sel),
    .period    (period),
    .open_from (open_from),
    .bad_combo (bad_combo)
  );

  wdg_run_ctrl u_run (
    .tick         (slow_tick),
    .osc_locked   (opt_osc_locked),
    .halt_req     (halt_req),
    .stop_req     (stop_req),
    .osc_stop_req (osc_stop_req),
    .frozen       (frozen),
    .run          (cnt_run)
  );

  wdg_restart_gate #(.DATA_W(DATA_W), .KEY(KEY)) u_gate (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .win_open (win_open),
    .key_ok   (key_ok),
    .key_bad  (key_bad)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cnt_run),
    .clear     (cnt_clear),
    .period    (period),
    .open_from (open_from),
    .count     (count),
    .last_tick (last_tick),
    .win_open  (win_open)
  );

  always_comb begin
    ovf_evt    = cnt_run && last_tick && !key_ok;
    fault_evt  = key_bad || ovf_evt;
    cnt_clear  = wr_en || ovf_evt;
    obs_count  = 32'(count);
    obs_period = 32'(period);
    cfg_error  = bad_combo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wdt_reset <= 1'b0;
    else        wdt_reset <= fault_evt;
  end

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wdt_reset,
  input logic        cfg_error,
  input logic        cnt_run,
  input logic        win_open,
  input logic        key_ok,
  input logic [31:0] obs_count,
  input logic [31:0] obs_period
);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && !wr_en && obs_count != obs_period - 32'd1) |=> obs_count == $past(obs_count) + 32'd1); // R1

  AST_OVERFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && !wr_en && obs_count == obs_period - 32'd1) |=> (wdt_reset && obs_count == 32'd0)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    obs_count < obs_period); // R2

  AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> (obs_count == 32'd0 && !wdt_reset)); // R3

  AST_BAD_WRITE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_ok) |=> (wdt_reset && obs_count == 32'd0)); // R5

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_run && !wr_en) |=> $stable(obs_count)); // R6

  AST_BAD_COMBO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> win_open); // R8

endmodule

bind slow_window_watchdog wdg_checker u_wdg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wdt_reset  (wdt_reset),
  .cfg_error  (cfg_error),
  .cnt_run    (cnt_run),
  .win_open   (win_open),
  .key_ok     (key_ok),
  .obs_count  (obs_count),
  .obs_period (obs_period)
);

// File: tb/slow_window_watchdog_bench.sv
`timescale 1ns/1ps
module slow_window_watchdog_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b1;
  logic [2:0] opt_ovf_sel = 3'd0;
  logic [1:0] opt_win_sel = 2'd2;
  logic       opt_osc_locked = 1'b1;
  logic       halt_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       osc_stop_req = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wdt_reset;
  logic       cfg_error;

  always #2 clk = ~clk;

  slow_window_watchdog u_slow_window_watchdog (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .opt_ovf_sel(opt_ovf_sel), .opt_win_sel(opt_win_sel),
    .opt_osc_locked(opt_osc_locked), .halt_req(halt_req),
    .stop_req(stop_req), .osc_stop_req(osc_stop_req),
    .wr_en(wr_en), .wr_data(wr_data),
    .wdt_reset(wdt_reset), .cfg_error(cfg_error)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int t0 = 0;
  int    q_at[$];
  string q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_pulse(int at, string req);
    q_at.push_back(at);
    q_req.push_back(req);
  endtask

  // monitor: every reset pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && wdt_reset) begin
      if (q_at.size() == 0) begin
        check(1'b0, "R2 unexpected pulse", cyc, -1);
      end else begin
        check(q_at[0] == cyc, q_req[0], cyc, q_at[0]);
        void'(q_at.pop_front());
        void'(q_req.pop_front());
      end
    end
  end

  task automatic drain();
    while (q_at.size() != 0 && q_at[0] < cyc) begin
      check(1'b0, q_req[0], -1, q_at[0]);
      void'(q_at.pop_front());
      void'(q_req.pop_front());
    end
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start(logic [2:0] sel, logic [1:0] win, logic locked);
    @(negedge clk);
    rst_n = 1'b0;
    opt_ovf_sel = sel; opt_win_sel = win; opt_osc_locked = locked;
    halt_req = 1'b0; stop_req = 1'b0; osc_stop_req = 1'b0;
    wr_en = 1'b0; slow_tick = 1'b1;
    repeat (3) @(negedge clk);
    check(wdt_reset == 1'b0, "R9 reset output", int'(wdt_reset), 0);
    check(cfg_error == (sel == 3'd0 && win == 2'd0), "R8 cfg flag",
          int'(cfg_error), int'(sel == 3'd0 && win == 2'd0));
    rst_n = 1'b1;
    t0 = cyc;
  endtask

  task automatic write_at(int t, logic [7:0] d);
    wait_to(t);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    int b;
    int c0;
    // R1 R2: plain overflow twice at 1024-tick period
    start(3'd0, 2'd2, 1'b1);
    expect_pulse(t0 + 1024, "R1 period 2^10");
    expect_pulse(t0 + 2048, "R2 restart from zero");
    wait_to(t0 + 2052); drain();

    // R3: key inside full window
    start(3'd0, 2'd2, 1'b1);
    expect_pulse(t0 + 501 + 1024, "R3 key restart");
    write_at(t0 + 500, 8'hAC);
    wait_to(t0 + 1530); drain();

    // R4 R5: half window, 2048 period; early key rejected, boundary key accepted
    start(3'd1, 2'd0, 1'b1);
    expect_pulse(t0 + 1001, "R5 closed window write");
    write_at(t0 + 1000, 8'hAC);
    b = t0 + 1001 + 1024;
    expect_pulse(b + 1 + 2048, "R4 half window edge");
    write_at(b, 8'hAC);
    wait_to(b + 2052); drain();

    // R4 R5: three-quarter window at 1024 period
    start(3'd0, 2'd1, 1'b1);
    expect_pulse(t0 + 256, "R4 quarter edge closed at 255");
    write_at(t0 + 255, 8'hAC);
    b = t0 + 256;
    write_at(b + 256, 8'hAC);
    c0 = b + 257;
    expect_pulse(c0 + 601, "R5 wrong key 0x55");
    write_at(c0 + 600, 8'h55);
    expect_pulse(c0 + 601 + 1024, "R2 period after fault");
    wait_to(c0 + 601 + 1030); drain();

    // R8: forbidden combo runs with full window
    start(3'd0, 2'd0, 1'b1);
    expect_pulse(t0 + 11 + 1024, "R8 key at count 10");
    write_at(t0 + 10, 8'hAC);
    check(cfg_error == 1'b1, "R8 flag held", int'(cfg_error), 1);
    wait_to(t0 + 1040); drain();

    // R6: halt 50 cycles and stop 30 cycles freeze
    start(3'd0, 2'd2, 1'b0);
    expect_pulse(t0 + 1024 + 80, "R6 halt/stop freeze");
    wait_to(t0 + 100); halt_req = 1'b1;
    wait_to(t0 + 150); halt_req = 1'b0;
    wait_to(t0 + 300); stop_req = 1'b1;
    wait_to(t0 + 330); stop_req = 1'b0;
    wait_to(t0 + 1110); drain();

    // R7: oscillator stop freezes when not locked
    start(3'd0, 2'd2, 1'b0);
    expect_pulse(t0 + 1024 + 40, "R7 osc stop freeze");
    wait_to(t0 + 200); osc_stop_req = 1'b1;
    wait_to(t0 + 240); osc_stop_req = 1'b0;
    wait_to(t0 + 1070); drain();

    // R7: locked option ignores all low-power requests
    start(3'd0, 2'd2, 1'b1);
    halt_req = 1'b1; stop_req = 1'b1; osc_stop_req = 1'b1;
    expect_pulse(t0 + 1024, "R7 locked ignores requests");
    wait_to(t0 + 1030);
    halt_req = 1'b0; stop_req = 1'b0; osc_stop_req = 1'b0;
    drain();

    // R1: tick every other cycle doubles the wall time
    start(3'd0, 2'd2, 1'b1);
    expect_pulse(t0 + 2047, "R1 tick gating");
    while (cyc < t0 + 2052) begin
      slow_tick = ((cyc - t0) % 2 == 0);
      @(negedge clk);
    end
    slow_tick = 1'b1;
    drain();

    check(q_at.size() == 0, "R2 queue empty", q_at.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired: actual %0d expected below %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule